// File: doc/BRIEF.md
# EPROM Identifier Readout Controller

This block fetches the two identifier bytes from an attached UV-erasable EPROM, so that a device programmer can choose the matching programming algorithm. A one-cycle `start` pulse puts the memory into identifier mode. The block raises a control that tells external circuitry to put the high voltage on address line 9, holds every other address line low, and pulls chip enable and output enable low.

The block then makes two reads: address 0 first, then address 1. Each read waits a parameterised number of settle cycles before it captures the low data byte. The first byte is the manufacturer code and the second is the device code. Bit 7 of each byte is an odd-parity bit. The block flags a parity error when either byte fails that check, and it reports both bytes in every case. When the readout is complete, the block releases the memory interface and pulses `done` for one cycle.

The block has no streaming data path. Results and controls are plain level signals, and there is no back-pressure. The results stay valid from the `done` pulse until the next readout finishes.

Top module: `idr_ctrl`

## Requirements
- R1: After reset, the outputs have these values: `mem_ce_n`=1, `mem_oe_n`=1, `id_hv_en`=0, `mem_addr`=0, `done`=0, `mfr_code`=0, `dev_code`=0, `parity_err`=0.
- R2: A `start` seen high at a clock edge while idle gives the following outputs from that edge on: `id_hv_en`=1, `mem_ce_n`=0, `mem_oe_n`=0 and `mem_addr`=0. Address bits 1 and up stay 0 for the whole readout.
- R3: Each read keeps its address steady for SETTLE+1 cycles. The data byte is captured at the clock edge that ends the last of these cycles.
- R4: The first read uses address 0 and its `mem_dq[7:0]` goes to `mfr_code`. The second read uses address 1 (`mem_addr[0]`=1) and its `mem_dq[7:0]` goes to `dev_code`. `mem_dq[15:8]` is ignored.
- R5: `parity_err` is 1 when either captured byte has an even number of ones. Both bytes are still reported unchanged.
- R6: In the cycle after the second capture, `id_hv_en`=0, `mem_ce_n`=1, `mem_oe_n`=1 and `mem_addr`=0. `done` is 1 for exactly that one cycle, and the block is then idle again.
- R7: A `start` that arrives during a readout, including the `done` cycle, has no effect.
- R8: `mfr_code` and `dev_code` change only at their capture edges. `parity_err` changes only at the edge that raises `done`. All three hold their values between readouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a readout (ignored when busy) |
| id_hv_en | output | 1 | Request high voltage on address line 9 |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | input | DATA_W | Memory data |
| mfr_code | output | 8 | Captured manufacturer byte |
| dev_code | output | 8 | Captured device byte |
| parity_err | output | 1 | Either byte had even parity |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The readout runs with four identifier pairs: both bytes odd, only the manufacturer byte even, only the device byte even, and both even. These cases separate a parity check that looks at one byte from one that looks at both, and they also catch swapped capture slots. The memory model drives a distinct upper byte, and it drives a marker value whenever the interface is not in identifier mode. A capture in the wrong cycle or of the wrong byte lane therefore shows up. Extra `start` pulses during each phase, and a `start` held high across several readouts, test whether the busy guard ignores them. The guard must still allow the back-to-back restart from idle.

// File: rtl/idr_pkg.sv
package idr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD0  = 2'd1,
    ST_RD1  = 2'd2,
    ST_FIN  = 2'd3
  } idr_state_e;

  localparam int unsigned ID_W = 8;
endpackage

// File: rtl/idr_settle_timer.sv
module idr_settle_timer #(
  parameter int unsigned SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expire
);
  localparam int unsigned CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt_q;

  assign expire = (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R3
endmodule

// File: rtl/idr_byte_latch.sv
module idr_byte_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         din_odd,
  output logic         q_odd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  assign din_odd = ^din;
  assign q_odd   = ^q;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R8
endmodule

// File: rtl/idr_ctrl.sv
module idr_ctrl
  import idr_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              id_hv_en,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_dq,
  output logic [7:0]        mfr_code,
  output logic [7:0]        dev_code,
  output logic              parity_err,
  output logic              done
);
  localparam int unsigned NSLOT = 2;

  idr_state_e state_q, state_d;
  logic       tmr_clr, tmr_done;
  logic [NSLOT-1:0] cap;
  logic [NSLOT-1:0] din_odd, q_odd;
  logic [ID_W-1:0]  slot_q [NSLOT];
  logic       perr_q;
  logic       busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)    state_d = ST_RD0;
      ST_RD0:  if (tmr_done) state_d = ST_RD1;
      ST_RD1:  if (tmr_done) state_d = ST_FIN;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign tmr_clr = (state_q == ST_IDLE) || (state_d != state_q);

  idr_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .expire (tmr_done)
  );

  assign cap[0] = (state_q == ST_RD0) && tmr_done;
  assign cap[1] = (state_q == ST_RD1) && tmr_done;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    idr_byte_latch #(.W(ID_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cap[i]),
      .din     (mem_dq[ID_W-1:0]),
      .q       (slot_q[i]),
      .din_odd (din_odd[i]),
      .q_odd   (q_odd[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      perr_q <= 1'b0;
    else if (cap[1]) perr_q <= !(q_odd[0] && din_odd[1]);
  end

  assign busy       = (state_q == ST_RD0) || (state_q == ST_RD1);
  assign id_hv_en   = busy;
  assign mem_ce_n   = !busy;
  assign mem_oe_n   = !busy;
  assign mem_addr   = {{(ADDR_W-1){1'b0}}, (state_q == ST_RD1)};
  assign mfr_code   = slot_q[0];
  assign dev_code   = slot_q[1];
  assign parity_err = perr_q;
  assign done       = (state_q == ST_FIN);

  AST_UPPER_ADDR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[ADDR_W-1:1] == '0); // R2
  AST_ENTER_ID_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> (id_hv_en && !mem_ce_n && !mem_oe_n && mem_addr == '0)); // R2
  AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD0 && !tmr_done) |=> (state_q == ST_RD0)); // R3
  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cap[0] |=> (mem_addr[0] && id_hv_en)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && mem_ce_n && !id_hv_en)); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cap[1] |=> (done && mem_ce_n && mem_oe_n && !id_hv_en && mem_addr == '0)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD1 && start) |=> (state_q != ST_RD0)); // R7
  AST_PERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(parity_err)); // R8
endmodule

// File: tb/idr_ctrl_test.sv
module idr_ctrl_test;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int S  = 3;
  localparam int L  = 2 * S + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic hv, ce_n, oe_n, done, perr;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq;
  logic [7:0] mfr, dev;
  logic [7:0] id0 = 8'h01, id1 = 8'h8F;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  idr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETTLE(S)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .id_hv_en(hv),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_addr(addr), .mem_dq(dq),
    .mfr_code(mfr), .dev_code(dev), .parity_err(perr), .done(done)
  );

  // memory model: identifier only in identifier mode, marker otherwise
  assign dq = (!ce_n && !oe_n && hv && addr[AW-1:1] == '0) ?
              {8'hA5, (addr[0] ? id1 : id0)} : 16'hDEAD;

  // behavioural reference
  int pos;
  logic [7:0] e_mfr, e_dev;
  logic e_perr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = -1; e_mfr = 0; e_dev = 0; e_perr = 0;
    end else if (pos < 0) begin
      if (start) pos = 0;
    end else begin
      if (pos == S) e_mfr = id0;
      if (pos == 2 * S + 1) begin
        e_dev  = id1;
        e_perr = ($countones(e_mfr) % 2 == 0) || ($countones(id1) % 2 == 0);
      end
      pos = pos + 1;
      if (pos == L) pos = -1;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      automatic bit rd  = (pos >= 0) && (pos <= 2 * S + 1);
      automatic bit rd1 = (pos > S) && (pos <= 2 * S + 1);
      string rq;
      rq = (pos < 0) ? "R1" : (pos == 2 * S + 2) ? "R6" : "R2";
      chk(rq, "id_hv_en", 32'(hv), 32'(rd));
      chk(rq, "mem_ce_n", 32'(ce_n), 32'(!rd));
      chk(rq, "mem_oe_n", 32'(oe_n), 32'(!rd));
      chk(rd1 ? "R4" : "R3", "mem_addr", 32'(addr), 32'(rd1));
      chk("R6", "done", 32'(done), 32'(pos == 2 * S + 2));
      chk("R4", "mfr_code", 32'(mfr), 32'(e_mfr));
      chk("R4", "dev_code", 32'(dev), 32'(e_dev));
      chk("R5", "parity_err", 32'(perr), 32'(e_perr));
    end
  end

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readout(input logic [7:0] m, input logic [7:0] d);
    @(negedge clk);
    id0 = m; id1 = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle_wait(L + 2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_wait(4);                 // R1 reset state compared each cycle
    rst_n = 1'b1;
    idle_wait(3);
    readout(8'h01, 8'h8F);        // R4 R5 both odd
    readout(8'h03, 8'h8F);        // R5 manufacturer even
    readout(8'h01, 8'h0F);        // R5 device even
    readout(8'h00, 8'hFF);        // R5 both even
    idle_wait(5);                 // R8 results hold while idle
    // R7: extra start pulses during each phase
    @(negedge clk); id0 = 8'h2A; id1 = 8'h07; start = 1'b1;
    @(negedge clk); start = 1'b0;
    idle_wait(1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    idle_wait(S);
    start = 1'b1; @(negedge clk); start = 1'b0;
    idle_wait(S - 1);
    start = 1'b1; @(negedge clk); start = 1'b0;   // lands in done cycle
    idle_wait(6);
    // R7: start held high across several readouts
    id0 = 8'h80; id1 = 8'h70; start = 1'b1;
    idle_wait(3 * L + 1);
    start = 1'b0;
    idle_wait(L + 3);
    finish_run();
  end
endmodule